// File: doc/BRIEF.md
# Predict-Taken Fetch Address Controller

This block chooses the address that the fetch stage of a five-stage in-order pipeline sends to instruction memory each cycle, and produces the control that recovers from wrong guesses. It keeps a predicted-address register in place of a plain program counter. The real fetch address is chosen from that register at the start of each cycle, unless a later stage forces a correction. Each fetched instruction sets the next prediction. For most instructions that is the address that follows it, found from the length its opcode implies. For jumps and calls it is the encoded target, so every conditional jump is guessed as taken.

Correction comes from two places. The first is the pipeline register between execute and memory. When it holds a conditional jump whose condition turned out false, the fall-through address carried down with that jump becomes the fetch address. In the same cycle, bubbles (a no-op with no destination register) are loaded into the decode and execute pipeline registers, so the two wrong-path instructions never change condition codes, memory or registers. The second is a return. Fetch stalls after a return until the surrounding pipeline signals that the return address is ready, and that address is then fetched. A jump correction always wins over a waiting return, because that return was itself on the wrong path.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: After reset the predicted address is 0: the first fetch address is 0, with no stall and no bubble.
- R2: With no correction, the next fetch address is the current one plus the length its 4-bit opcode implies: 1 for opcodes 0x0, 0x1, 0x9 and any unlisted code; 2 for 0x2, 0x6, 0xA, 0xB; 9 for 0x7 and 0x8; 10 for 0x3, 0x4, 0x5.
- R3: Opcode 0x7 (jump, conditional or not) and opcode 0x8 (call) are predicted taken: the fetch address in the next cycle is the target that came with them.
- R4: When the memory-stage register holds a conditional jump whose condition was not met, the fetch address in that cycle is the carried fall-through address, and the decode and execute bubble outputs are both 1 in that cycle. If the condition was met, or no conditional jump is present, there is no correction and neither bubble is raised.
- R5: A return (opcode 0x9) fetched in a cycle with no stall starts a wait in the next cycle. While waiting, fetch stall and decode bubble are 1, execute bubble is 0, and the fetch address holds at the return's address plus 1. In the cycle the return-ready input is 1, the fetch address is the supplied return address, with no stall and no bubble.
- R6: The return-ready input and return address have no effect when no return is waiting.
- R7: A jump correction in a cycle where a return is waiting takes priority: the fall-through address is fetched, both bubbles are raised, fetch stall is 0, and the wait ends.
- R8: The bubble word output is the no-op opcode 0x1 in bits 7:4 and the no-destination register code 0xF in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | output | ADDR_W | Address sent to instruction memory this cycle |
| fetch_opcode | input | 4 | Opcode of the instruction read at fetch_pc |
| fetch_target | input | ADDR_W | Jump or call target encoded in that instruction |
| mem_is_cjump | input | 1 | Memory-stage register holds a conditional jump |
| mem_cond_met | input | 1 | That jump's condition was met |
| mem_fallthru | input | ADDR_W | Fall-through address carried with that jump |
| ret_ready | input | 1 | The waiting return's address is available |
| ret_addr | input | ADDR_W | The return address |
| fetch_stall | output | 1 | Hold the fetch stage this cycle |
| decode_bubble | output | 1 | Load a bubble into the decode pipeline register |
| execute_bubble | output | 1 | Load a bubble into the execute pipeline register |
| bubble_word | output | 8 | Bubble encoding: opcode and destination |

## Verification
The bench builds the block with its default 64-bit address width, with every target and fall-through address taken from a small program of its own. That program brings a correctly guessed jump, a wrong guess, a return that waits three cycles, and a wrong guess that lands during a return wait into a single run. With the full address width, the sum of current address and length, and the selection among the three correction sources, are checked at real size. The bench also uses a return-ready pulse that arrives while nothing is waiting, and a memory-stage condition flag raised with no jump present. Both of these would disturb the fetch address in a design that decoded its inputs too loosely.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int OP_W  = 4;
    localparam int LEN_W = 4;

    localparam logic [OP_W-1:0] OPC_STOP  = 4'h0;
    localparam logic [OP_W-1:0] OPC_NOP   = 4'h1;
    localparam logic [OP_W-1:0] OPC_MOVRR = 4'h2;
    localparam logic [OP_W-1:0] OPC_LDI   = 4'h3;
    localparam logic [OP_W-1:0] OPC_ST    = 4'h4;
    localparam logic [OP_W-1:0] OPC_LD    = 4'h5;
    localparam logic [OP_W-1:0] OPC_ALU   = 4'h6;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'h7;
    localparam logic [OP_W-1:0] OPC_CALL  = 4'h8;
    localparam logic [OP_W-1:0] OPC_RET   = 4'h9;
    localparam logic [OP_W-1:0] OPC_PUSH  = 4'hA;
    localparam logic [OP_W-1:0] OPC_POP   = 4'hB;

    localparam logic [3:0] REG_NONE = 4'hF;

    localparam logic [LEN_W-1:0] LEN_ONE  = 4'd1;
    localparam logic [LEN_W-1:0] LEN_PAIR = 4'd2;
    localparam logic [LEN_W-1:0] LEN_BR   = 4'd9;
    localparam logic [LEN_W-1:0] LEN_IMM  = 4'd10;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_TARGET = 2'd1,
        FLOW_RETURN = 2'd2
    } flow_e;
endpackage

// File: rtl/fpc_len_decode.sv
module fpc_len_decode
    import fpc_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    output logic [LEN_W-1:0] length,
    output flow_e            flow
);
    always_comb begin
        length = LEN_ONE;
        flow   = FLOW_SEQ;
        unique case (opcode)
            OPC_MOVRR, OPC_ALU, OPC_PUSH, OPC_POP: length = LEN_PAIR;
            OPC_LDI, OPC_ST, OPC_LD:               length = LEN_IMM;
            OPC_JUMP, OPC_CALL: begin
                length = LEN_BR;
                flow   = FLOW_TARGET;
            end
            OPC_RET: begin
                length = LEN_ONE;
                flow   = FLOW_RETURN;
            end
            default: length = LEN_ONE;
        endcase
    end
endmodule

// File: rtl/fpc_redirect_sel.sv
module fpc_redirect_sel #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic              ret_wait,
    input  logic              mem_is_cjump,
    input  logic              mem_cond_met,
    input  logic [ADDR_W-1:0] mem_fallthru,
    input  logic              ret_ready,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] sel_pc,
    output logic              hold,
    output logic              squash
);
    logic resume;

    always_comb begin
        squash = mem_is_cjump && !mem_cond_met;
        resume = ret_wait && ret_ready && !squash;
        hold   = ret_wait && !ret_ready && !squash;
        if (squash)      sel_pc = mem_fallthru;
        else if (resume) sel_pc = ret_addr;
        else             sel_pc = pred_pc;
    end
endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] fetch_pc,
    input  logic [3:0]        fetch_opcode,
    input  logic [ADDR_W-1:0] fetch_target,
    input  logic              mem_is_cjump,
    input  logic              mem_cond_met,
    input  logic [ADDR_W-1:0] mem_fallthru,
    input  logic              ret_ready,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic              fetch_stall,
    output logic              decode_bubble,
    output logic              execute_bubble,
    output logic [7:0]        bubble_word
);
    localparam int PAD_W = ADDR_W - LEN_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pred;
        logic              wait_ret;
    } state_t;

    state_t state_d, state_q;

    logic [LEN_W-1:0]  op_len;
    flow_e             op_flow;
    logic [ADDR_W-1:0] sel_pc;
    logic              hold;
    logic              squash;
    logic [ADDR_W-1:0] seq_pc;

    fpc_len_decode u_dec (
        .opcode (fetch_opcode),
        .length (op_len),
        .flow   (op_flow)
    );

    fpc_redirect_sel #(.ADDR_W(ADDR_W)) u_sel (
        .pred_pc      (state_q.pred),
        .ret_wait     (state_q.wait_ret),
        .mem_is_cjump (mem_is_cjump),
        .mem_cond_met (mem_cond_met),
        .mem_fallthru (mem_fallthru),
        .ret_ready    (ret_ready),
        .ret_addr     (ret_addr),
        .sel_pc       (sel_pc),
        .hold         (hold),
        .squash       (squash)
    );

    always_comb begin
        seq_pc  = sel_pc + {{PAD_W{1'b0}}, op_len};
        state_d = state_q;
        if (!hold) begin
            state_d.pred     = (op_flow == FLOW_TARGET) ? fetch_target : seq_pc;
            state_d.wait_ret = (op_flow == FLOW_RETURN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_pc       = sel_pc;
    assign fetch_stall    = hold;
    assign decode_bubble  = squash || hold;
    assign execute_bubble = squash;
    assign bubble_word    = {OPC_NOP, REG_NONE};

    // R3: a fetched jump or call steers the next fetch to its target
    assert_taken_guess_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && (fetch_opcode == OPC_JUMP || fetch_opcode == OPC_CALL))
        |=> ((mem_is_cjump && !mem_cond_met) || fetch_pc == $past(fetch_target)));

    // R2: a two-byte opcode advances the fetch address by two
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && fetch_opcode == OPC_ALU)
        |=> ((mem_is_cjump && !mem_cond_met) || fetch_pc == $past(fetch_pc) + ADDR_W'(2)));

    // R4: a failed conditional jump redirects and squashes both stages
    assert_mispredict_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_is_cjump && !mem_cond_met)
        |-> (fetch_pc == mem_fallthru && decode_bubble && execute_bubble));

    // R5: a stall only begins right after a return was fetched
    assert_stall_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_stall) |-> $past(fetch_opcode == OPC_RET));

    // R5: the fetch address holds across consecutive stall cycles
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && $past(fetch_stall)) |-> $stable(fetch_pc));

    // R7: a correction never coexists with a stall
    assert_redirect_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_is_cjump && !mem_cond_met) |-> !fetch_stall);
endmodule

// File: tb/fetch_pc_ctrl_test.sv
`timescale 1ns/1ps
module fetch_pc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] fetch_pc;
    logic [3:0]  fetch_opcode;
    logic [63:0] fetch_target;
    logic        mem_is_cjump = 1'b0;
    logic        mem_cond_met = 1'b0;
    logic [63:0] mem_fallthru = '0;
    logic        ret_ready = 1'b0;
    logic [63:0] ret_addr = '0;
    logic        fetch_stall;
    logic        decode_bubble;
    logic        execute_bubble;
    logic [7:0]  bubble_word;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [3:0] prog_op(input logic [63:0] a);
        case (a)
            64'd0, 64'd100, 64'd102, 64'd200, 64'd202,
            64'd300, 64'd311, 64'd521:                 return 4'h6;
            64'd2, 64'd500:                            return 4'h3;
            64'd12, 64'd104, 64'd302:                  return 4'h7;
            64'd113, 64'd400:                          return 4'h9;
            64'd313:                                   return 4'h8;
            64'd510:                                   return 4'h0;
            64'd511:                                   return 4'h4;
            default:                                   return 4'h1;
        endcase
    endfunction

    function automatic logic [63:0] prog_tgt(input logic [63:0] a);
        case (a)
            64'd12:  return 64'd100;
            64'd104: return 64'd200;
            64'd302: return 64'd400;
            64'd313: return 64'd500;
            default: return 64'd0;
        endcase
    endfunction

    assign fetch_opcode = prog_op(fetch_pc);
    assign fetch_target = prog_tgt(fetch_pc);

    fetch_pc_ctrl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .fetch_opcode   (fetch_opcode),
        .fetch_target   (fetch_target),
        .mem_is_cjump   (mem_is_cjump),
        .mem_cond_met   (mem_cond_met),
        .mem_fallthru   (mem_fallthru),
        .ret_ready      (ret_ready),
        .ret_addr       (ret_addr),
        .fetch_stall    (fetch_stall),
        .decode_bubble  (decode_bubble),
        .execute_bubble (execute_bubble),
        .bubble_word    (bubble_word)
    );

    typedef struct {
        logic [63:0] pc;
        logic        st;
        logic        db;
        logic        eb;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic put(input logic cj, input logic cm, input logic [63:0] fall,
                       input logic rr, input logic [63:0] ra,
                       input logic [63:0] pc, input logic st, input logic db,
                       input logic eb, input string tag);
        exp_t e;
        mem_is_cjump = cj;
        mem_cond_met = cm;
        mem_fallthru = fall;
        ret_ready    = rr;
        ret_addr     = ra;
        e.pc = pc; e.st = st; e.db = db; e.eb = eb; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic cyc(input logic cj, input logic cm, input logic [63:0] fall,
                       input logic rr, input logic [63:0] ra,
                       input logic [63:0] pc, input logic st, input logic db,
                       input logic eb, input string tag);
        @(posedge clk);
        #1;
        put(cj, cm, fall, rr, ra, pc, st, db, eb, tag);
    endtask

    // monitor: compares one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (fetch_pc !== e.pc || fetch_stall !== e.st ||
                decode_bubble !== e.db || execute_bubble !== e.eb) begin
                fails++;
                $display("FAIL %s: got pc=%0d stall=%0b dbub=%0b ebub=%0b, expected pc=%0d stall=%0b dbub=%0b ebub=%0b",
                         e.tag, fetch_pc, fetch_stall, decode_bubble, execute_bubble,
                         e.pc, e.st, e.db, e.eb);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (fetch_pc !== 64'd0 || fetch_stall !== 1'b0 || decode_bubble !== 1'b0) begin
            fails++;
            $display("FAIL R1 during reset: got pc=%0d stall=%0b dbub=%0b, expected pc=0 stall=0 dbub=0",
                     fetch_pc, fetch_stall, decode_bubble);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        put(0, 0, 0, 0, 0, 64'd0,   0, 0, 0, "R1 first fetch at 0");
        cyc(0, 0, 0, 0, 0, 64'd2,   0, 0, 0, "R2 two-byte step");
        cyc(0, 0, 0, 0, 0, 64'd12,  0, 0, 0, "R2 ten-byte step");
        cyc(0, 0, 0, 0, 0, 64'd100, 0, 0, 0, "R3 jump target next cycle");
        cyc(0, 0, 0, 0, 0, 64'd102, 0, 0, 0, "R2 step on target path");
        cyc(1, 1, 64'd21, 0, 0, 64'd104, 0, 0, 0, "R4 condition met, no correction");
        cyc(0, 0, 0, 0, 0, 64'd200, 0, 0, 0, "R3 second jump target");
        cyc(0, 0, 0, 0, 0, 64'd202, 0, 0, 0, "R2 wrong-path step");
        cyc(1, 0, 64'd113, 0, 0, 64'd113, 0, 1, 1, "R4 mispredict fall-through and bubbles");
        cyc(0, 0, 0, 0, 0, 64'd114, 1, 1, 0, "R5 return wait cycle 1");
        cyc(0, 0, 0, 0, 0, 64'd114, 1, 1, 0, "R5 return wait cycle 2");
        cyc(0, 0, 0, 1, 64'd300, 64'd300, 0, 0, 0, "R5 return address fetched");
        cyc(0, 0, 0, 0, 0, 64'd302, 0, 0, 0, "R2 step after return");
        cyc(0, 0, 0, 0, 0, 64'd400, 0, 0, 0, "R3 jump to return on wrong path");
        cyc(0, 0, 0, 0, 0, 64'd401, 1, 1, 0, "R5 wait on wrong-path return");
        cyc(1, 0, 64'd311, 0, 0, 64'd311, 0, 1, 1, "R7 correction beats return wait");
        cyc(0, 0, 0, 1, 64'd999, 64'd313, 0, 0, 0, "R6 ready ignored, R7 wait ended");
        cyc(0, 0, 0, 0, 0, 64'd500, 0, 0, 0, "R3 call target");
        cyc(1, 1, 64'd77, 0, 0, 64'd510, 0, 0, 0, "R2 ten-byte step, R4 met no correction");
        cyc(0, 1, 64'd77, 0, 0, 64'd511, 0, 0, 0, "R2 one-byte step, R4 flag without jump");
        cyc(0, 0, 0, 0, 0, 64'd521, 0, 0, 0, "R2 ten-byte store step");
        @(posedge clk);
        #1;
        put(0, 0, 0, 0, 0, 64'd523, 0, 0, 0, "R2 final step");
        @(negedge clk);
        @(negedge clk);
        tests++;
        if (bubble_word !== 8'h1F) begin
            fails++;
            $display("FAIL R8 bubble word: got %h, expected 1f", bubble_word);
        end
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule